// File: doc/BRIEF.md
# Pipelined 64x64 Multiplier with Addend and Result Inversion

This block multiplies two unsigned 64-bit operands and returns the full 128-bit product. It accepts a new operation on every clock cycle and delivers each result after a fixed four-cycle latency. It never stalls and never applies back-pressure.

Two extra controls travel with each operation. The first is a 128-bit addend that is added to the product. The second is an invert flag that complements every bit of that sum. Together they let the surrounding datapath form signed products from operand magnitudes. The caller passes in the magnitudes, sets the invert flag to the XOR of the operand signs, and fills the addend with copies of that same sign bit. Adding all ones and then inverting gives the two's-complement negation of the product, so no separate negate stage is needed.

Thirty-two-bit forms use the same path. The caller zero-extends the 32-bit magnitudes into the 64-bit operands and then takes the low half or the middle word of the result.

Top module: `mul_pipe64`

## Requirements
- R1: While reset is asserted and immediately after it, `out_vld` is 0 and `result` is all zeros.
- R2: `out_vld` is high exactly four clock edges after the edge that sampled `in_vld` high, for one cycle per accepted input. It is never high at any other time.
- R3: Inputs accepted on consecutive cycles produce results on consecutive cycles. Each result uses its own operands, addend and invert flag.
- R4: With `invert` = 0, `result` equals `op_a * op_b + addend`, taken modulo 2^128.
- R5: With `invert` = 1, `result` equals the bitwise complement of `op_a * op_b + addend`, taken modulo 2^128.
- R6: Suppose the operands are the magnitudes of two signed 64-bit values, `invert` is the XOR of their signs, and `addend` is 128 copies of that bit. Then `result` is the 128-bit two's-complement signed product, and a zero magnitude gives zero.
- R7: 0x1000 times 0x1111, with a zero addend and `invert` = 0, gives 0x1111000.
- R8: While `out_vld` is low, `result` holds its previous value. Operand and control values presented with `in_vld` low have no effect on either output.
- R9: Extreme operands are exact. All-ones times all-ones gives 0xFFFFFFFFFFFFFFFE_0000000000000001, and a zero operand gives the addend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation accepted on this edge |
| op_a | input | 64 | Unsigned multiplicand |
| op_b | input | 64 | Unsigned multiplier |
| addend | input | 128 | Value added to the product |
| invert | input | 1 | Complement the sum before output |
| out_vld | output | 1 | Result valid, one cycle per operation |
| result | output | 128 | Product plus addend, optionally complemented |

## Verification
The bench targets cross-half carries. All-ones operands and random full-width addends expose a reducer that drops carries between the 32-bit partial products, or an adder that is one bit too narrow; either fault yields a corrupted upper half. Signed cases include the most negative magnitude and zero times a negative value. The zero case catches a design that inverts without the all-ones addend, because that design returns all ones instead of zero.

Dense back-to-back bursts with mixed control values catch a pipeline that loses or misaligns a result, and one whose controls slip a stage away from their own product. Such a design applies another operation's invert flag and fails the comparison.

Idle stretches with changing operands catch a design that loads its registers without regard to valid, because its `result` would then drift while `out_vld` is low.

// File: rtl/mul_pipe_pkg.sv
package mul_pipe_pkg;
  // Number of register stages between input sampling and output valid.
  localparam int unsigned PIPE_STAGES = 4;
  // Operands are split into two halves, so there are four partial products.
  localparam int unsigned NUM_PARTS   = 4;
endpackage

// File: rtl/mul_pipe_reg.sv
module mul_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mul_partials.sv
module mul_partials #(
  parameter int unsigned OP_W = 64
) (
  input  logic [OP_W-1:0]                       a,
  input  logic [OP_W-1:0]                       b,
  output logic [mul_pipe_pkg::NUM_PARTS-1:0][OP_W-1:0] pp
);
  localparam int unsigned HALF_W = OP_W / 2;

  logic [1:0][HALF_W-1:0] a_h;
  logic [1:0][HALF_W-1:0] b_h;

  assign a_h = a;
  assign b_h = b;

  // pp[2*i+j] = a half i times b half j; its weight is (i+j)*HALF_W.
  for (genvar gi = 0; gi < 2; gi++) begin : g_ai
    for (genvar gj = 0; gj < 2; gj++) begin : g_bj
      assign pp[gi*2+gj] = OP_W'(a_h[gi]) * OP_W'(b_h[gj]);
    end
  end
endmodule

// File: rtl/mul_reduce.sv
module mul_reduce #(
  parameter int unsigned OP_W = 64
) (
  input  logic [mul_pipe_pkg::NUM_PARTS-1:0][OP_W-1:0] pp,
  output logic [2*OP_W-1:0]                            prod
);
  localparam int unsigned HALF_W = OP_W / 2;
  localparam int unsigned RES_W  = 2 * OP_W;
  localparam int unsigned NP     = mul_pipe_pkg::NUM_PARTS;

  logic [NP-1:0][RES_W-1:0] term;

  for (genvar gk = 0; gk < NP; gk++) begin : g_term
    localparam int unsigned SH = ((gk / 2) + (gk % 2)) * HALF_W;
    assign term[gk] = RES_W'(pp[gk]) << SH;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < NP; k++) prod = prod + term[k];
  end
endmodule

// File: rtl/mul_pipe64.sv
module mul_pipe64 #(
  parameter int unsigned OP_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  input  logic [2*OP_W-1:0]   addend,
  input  logic                invert,
  output logic                out_vld,
  output logic [2*OP_W-1:0]   result
);
  localparam int unsigned RES_W = 2 * OP_W;
  localparam int unsigned NS    = mul_pipe_pkg::PIPE_STAGES;
  localparam int unsigned NP    = mul_pipe_pkg::NUM_PARTS;
  localparam int unsigned PP_W  = NP * OP_W;

  // Valid shift chain
  logic [NS-1:0] vld_q;
  logic [NS-1:0] vld_d;

  assign vld_d = {vld_q[NS-2:0], in_vld};

  mul_pipe_reg #(.W(NS)) u_vld (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .d(vld_d), .q(vld_q)
  );

  // Stage 1: partial products plus controls
  logic [NP-1:0][OP_W-1:0] pp_d;
  logic [PP_W-1:0]         s1_pp_q;
  logic [RES_W-1:0]        s1_add_q;
  logic                    s1_inv_q;

  mul_partials #(.OP_W(OP_W)) u_parts (
    .a(op_a), .b(op_b), .pp(pp_d)
  );

  mul_pipe_reg #(.W(PP_W + RES_W + 1)) u_s1 (
    .clk(clk), .rst_n(rst_n), .en(in_vld),
    .d({pp_d, addend, invert}),
    .q({s1_pp_q, s1_add_q, s1_inv_q})
  );

  // Stage 2: reduced product plus controls
  logic [NP-1:0][OP_W-1:0] s1_pp;
  logic [RES_W-1:0]        prod_d;
  logic [RES_W-1:0]        s2_prod_q;
  logic [RES_W-1:0]        s2_add_q;
  logic                    s2_inv_q;

  assign s1_pp = s1_pp_q;

  mul_reduce #(.OP_W(OP_W)) u_red (
    .pp(s1_pp), .prod(prod_d)
  );

  mul_pipe_reg #(.W(2*RES_W + 1)) u_s2 (
    .clk(clk), .rst_n(rst_n), .en(vld_q[0]),
    .d({prod_d, s1_add_q, s1_inv_q}),
    .q({s2_prod_q, s2_add_q, s2_inv_q})
  );

  // Stage 3: accumulate the addend
  logic [RES_W-1:0] sum_d;
  logic [RES_W-1:0] s3_sum_q;
  logic             s3_inv_q;

  assign sum_d = s2_prod_q + s2_add_q;

  mul_pipe_reg #(.W(RES_W + 1)) u_s3 (
    .clk(clk), .rst_n(rst_n), .en(vld_q[1]),
    .d({sum_d, s2_inv_q}),
    .q({s3_sum_q, s3_inv_q})
  );

  // Stage 4: optional complement
  logic [RES_W-1:0] fin_d;

  always_comb begin
    fin_d = s3_sum_q;
    if (s3_inv_q) fin_d = ~s3_sum_q;
  end

  mul_pipe_reg #(.W(RES_W)) u_s4 (
    .clk(clk), .rst_n(rst_n), .en(vld_q[2]),
    .d(fin_d), .q(result)
  );

  assign out_vld = vld_q[NS-1];
endmodule

// File: rtl/mul_pipe64_chk.sv
module mul_pipe64_chk #(
  parameter int unsigned OP_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [2*OP_W-1:0] addend,
  input logic              invert,
  input logic              out_vld,
  input logic [2*OP_W-1:0] result
);
  localparam int unsigned RES_W = 2 * OP_W;

  // Edges since reset release, saturating at 4.
  logic [2:0] seen_q;
  logic [2:0] seen_d;

  always_comb begin
    seen_d = seen_q;
    if (seen_q != 3'd4) seen_d = seen_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  // R1: outputs stay cleared while reset is held
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && result == '0));

  // R2: valid out matches valid in four edges earlier
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd4) |-> (out_vld == $past(in_vld, 4)));

  // R4: plain accumulation
  assert_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd4 && $past(in_vld, 4) && !$past(invert, 4)) |->
      (result == (RES_W'($past(op_a, 4)) * RES_W'($past(op_b, 4)) + $past(addend, 4))));

  // R5: complemented accumulation
  assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 3'd4 && $past(in_vld, 4) && $past(invert, 4)) |->
      (result == ~(RES_W'($past(op_a, 4)) * RES_W'($past(op_b, 4)) + $past(addend, 4))));

  // R8: result holds while no valid output
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(result));
endmodule

bind mul_pipe64 mul_pipe64_chk #(.OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
  .addend(addend), .invert(invert), .out_vld(out_vld), .result(result)
);

// File: tb/mul_pipe64_tb_top.sv
module mul_pipe64_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [63:0]   op_a = '0;
  logic [63:0]   op_b = '0;
  logic [127:0]  addend = '0;
  logic          invert = 1'b0;
  logic          out_vld;
  logic [127:0]  result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pulses = 0;
  int sent   = 0;

  logic [127:0] exp_q[$];
  int           cyc_q[$];
  string        tag_q[$];

  always #5 clk = ~clk;

  mul_pipe64 dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .addend(addend), .invert(invert), .out_vld(out_vld), .result(result)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic [127:0] add, input logic inv);
    logic [127:0] s;
    s = {64'd0, a} * {64'd0, b} + add;
    return inv ? ~s : s;
  endfunction

  // Driver: called at a negedge, leaves the bench at the next negedge.
  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic [127:0] add, input logic inv,
                      input logic [127:0] exp, input string tag);
    in_vld = 1'b1; op_a = a; op_b = b; addend = add; invert = inv;
    exp_q.push_back(exp);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
    sent++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [127:0] r128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic send_signed(input logic [63:0] sa, input logic [63:0] sb, input string tag);
    logic [63:0]  ma, mb;
    logic         s;
    logic [127:0] ex;
    ma = sa[63] ? (~sa + 64'd1) : sa;
    mb = sb[63] ? (~sb + 64'd1) : sb;
    s  = sa[63] ^ sb[63];
    ex = {{64{sa[63]}}, sa} * {{64{sb[63]}}, sb};
    send(ma, mb, {128{s}}, s, ex, tag);
  endtask

  // Monitor: scoreboard compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      pulses++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", {127'd0, out_vld}, 128'd0);
      end else begin
        logic [127:0] e;
        int           c;
        string        t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        chk(result == e, t, result, e);
        chk(cyc == c + 4, "R2 latency", 128'(cyc), 128'(c + 4));
      end
    end
  end

  initial begin
    logic [127:0] held;
    logic [63:0]  a, b;
    logic [127:0] ad;
    logic         iv;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld in reset", {127'd0, out_vld}, 128'd0);
    chk(result == '0, "R1 result in reset", result, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld after reset", {127'd0, out_vld}, 128'd0);
    chk(result == '0, "R1 result after reset", result, 128'd0);

    // R7: known example
    send(64'h1000, 64'h1111, '0, 1'b0, 128'h1111000, "R7 example");
    idle(7);

    // R2: isolated operations with gaps
    for (int i = 0; i < 4; i++) begin
      a = r64(); b = r64();
      send(a, b, '0, 1'b0, model(a, b, '0, 1'b0), "R2 spaced");
      idle(i + 1);
    end
    idle(6);

    // R3: back-to-back burst with mixed controls
    for (int i = 0; i < 24; i++) begin
      a = r64(); b = r64(); ad = r128(); iv = i[0] ^ i[2];
      send(a, b, ad, iv, model(a, b, ad, iv), "R3 burst");
    end
    idle(6);

    // R4 and R5: addend, with and without complement
    for (int i = 0; i < 10; i++) begin
      a = r64(); b = r64(); ad = r128();
      send(a, b, ad, 1'b0, model(a, b, ad, 1'b0), "R4 addend");
      send(a, b, ad, 1'b1, model(a, b, ad, 1'b1), "R5 invert");
    end
    idle(6);

    // R6: signed products built from magnitudes
    send_signed(64'hFFFF_FFFF_FFFF_FFFD, 64'd7, "R6 neg x pos");
    send_signed(64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFF0, "R6 neg x neg");
    send_signed(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6 most negative");
    send_signed(64'd0, 64'hFFFF_FFFF_FFFF_FF00, "R6 zero x neg");
    for (int i = 0; i < 8; i++) send_signed(r64(), r64(), "R6 random");
    idle(6);

    // R9: extremes
    send('1, '1, '0, 1'b0, 128'hFFFFFFFFFFFFFFFE_0000000000000001, "R9 all ones");
    ad = r128();
    send('0, r64(), ad, 1'b0, ad, "R9 zero operand");
    send('1, '1, '1, 1'b0, 128'hFFFFFFFFFFFFFFFE_0000000000000000, "R9 wrap");
    idle(7);

    // R8: inputs ignored while in_vld is low, result holds
    held = result;
    for (int i = 0; i < 6; i++) begin
      op_a = r64(); op_b = r64(); addend = r128(); invert = ~invert;
      @(negedge clk);
      chk(out_vld == 1'b0, "R8 no valid when idle", {127'd0, out_vld}, 128'd0);
      chk(result == held, "R8 result held", result, held);
    end
    idle(6);

    // R2: every accepted operation produced one pulse
    chk(exp_q.size() == 0, "R2 scoreboard drained", 128'(exp_q.size()), 128'd0);
    chk(pulses == sent, "R2 pulse count", 128'(pulses), 128'(sent));

    summary();
    $finish;
  end
endmodule